// File: doc/BRIEF.md
# Delayed GPIO Input Event Unit

This block takes an eight-channel input port through a two-flop synchronizer. Each channel then passes through a delay line whose length software sets to 0, 1, 2 or 3 clocks. The delayed levels can be read back as a status word. A per-channel detector watches each delayed channel for a chosen level or edge condition. A hit sets a sticky raw flag. The raw flags are qualified by a per-channel enable to form the status word. The status bits are ORed together onto one interrupt line. Software clears a raw flag by writing a 1 to its bit in a clear register.

Software reaches the block through a simple register port with an address, a write strobe, write data and combinational read data. Reads have no side effects. Writes to read-only locations are dropped. The block uses one clock and an asynchronous active-low reset. The reset is released through a two-stage synchronizer inside the block.

Top module: `gpio_in_irq`

## Requirements
- R1: Reset clears the delay, trigger, raw and enable registers and the masked status. The interrupt line is low during reset and after it.
- R2: The delay register sits at offset 0x14, with channel n's 2-bit field in bits [2n+1:2n]. A field value k delays channel n by k clocks beyond the synchronizer. The input status word at offset 0x18, bits [7:0], shows the delayed levels. A change on the input port therefore appears there 2+k clock edges after it is applied.
- R3: Trigger codes 0 and 1 never set the channel's raw flag, whatever the input does.
- R4: Code 2 (low level) and code 3 (high level) set the raw flag while the delayed input holds that level. The flag is set again on the next edge after a clear if the level is still present.
- R5: Code 4 (falling), code 5 (rising), and codes 6 and 7 (either edge) compare the delayed sample with the delayed sample of the previous clock. A match sets the raw flag one edge after the delayed input changes.
- R6: The raw flags are read at offset 0x20, bits [7:0]. They are sticky, and a write to 0x20 does not change them.
- R7: The enable register at offset 0x24 is read/write with one bit per channel. The status word at offset 0x28 equals the raw flags ANDed with the enables.
- R8: Writing to offset 0x2C clears the raw flags whose data bits are 1 and leaves the others alone. If a channel's condition is met in the same cycle, the flag stays set.
- R9: The interrupt output is high exactly when at least one status bit is high.
- R10: The trigger register at offset 0x1C holds channel n's 3-bit code in bits [3n+2:3n]. The delay and trigger registers read back what was written. Reads of the clear offset and of unmapped offsets return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pad_in | input | 8 | Raw input channels from the pads |
| bus_addr | input | 6 | Register byte offset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| irq | output | 1 | OR of all masked status bits |

## Verification
An input change reaches the input status word after 2+k edges: two synchronizer stages plus the programmed delay. It reaches a raw flag one edge after that. Register writes take effect at the edge the strobe is sampled. Reads and the interrupt line follow the registers with no extra cycle. The stimulus table gives every step exactly one clock, so each expected value is placed at the step where that edge count has elapsed. The delay test reads the status word once per clock, so each tap is caught in the cycle it arrives. All inputs change on the falling clock edge and outputs are compared shortly after it, away from the sampling edge.

// File: rtl/gpio_in_irq_pkg.sv
package gpio_in_irq_pkg;

  // Trigger codes decoded per channel
  typedef enum logic [2:0] {
    TRIG_OFF_A  = 3'd0,
    TRIG_OFF_B  = 3'd1,
    TRIG_LOW    = 3'd2,
    TRIG_HIGH   = 3'd3,
    TRIG_FALL   = 3'd4,
    TRIG_RISE   = 3'd5,
    TRIG_EDGE_A = 3'd6,
    TRIG_EDGE_B = 3'd7
  } trig_mode_e;

  // Register byte offsets
  localparam int OFF_DLY   = 'h14;
  localparam int OFF_INSTS = 'h18;
  localparam int OFF_TRIG  = 'h1C;
  localparam int OFF_RAW   = 'h20;
  localparam int OFF_ENA   = 'h24;
  localparam int OFF_STS   = 'h28;
  localparam int OFF_CLR   = 'h2C;

  // Condition check for one channel from the current and previous delayed sample
  function automatic logic trig_hit(input trig_mode_e mode, input logic cur, input logic prv);
    logic res;
    case (mode)
      TRIG_LOW:    res = ~cur;
      TRIG_HIGH:   res = cur;
      TRIG_FALL:   res = prv & ~cur;
      TRIG_RISE:   res = ~prv & cur;
      TRIG_EDGE_A,
      TRIG_EDGE_B: res = prv ^ cur;
      default:     res = 1'b0;
    endcase
    return res;
  endfunction

endpackage

// File: rtl/gpio_in_irq_sync.sv
module gpio_in_irq_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage1_q;
  logic [W-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= d;
      stage2_q <= stage1_q;
    end
  end

  assign q = stage2_q;

endmodule

// File: rtl/gpio_in_irq_dly_lane.sv
module gpio_in_irq_dly_lane #(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             din,
  input  logic [SEL_W-1:0] sel,
  output logic             dout
);

  localparam int DEPTH = (1 << SEL_W) - 1;

  logic [DEPTH:1]   tap_q;
  logic [DEPTH:1]   tap_d;
  logic [DEPTH:0]   chain;

  assign chain = {tap_q, din};

  always_comb begin
    tap_d = chain[DEPTH-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tap_q <= '0;
    end else begin
      tap_q <= tap_d;
    end
  end

  assign dout = chain[sel];

endmodule

// File: rtl/gpio_in_irq_edge_det.sv
module gpio_in_irq_edge_det
  import gpio_in_irq_pkg::*;
#(
  parameter int MODE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp,
  input  logic [MODE_W-1:0] mode,
  output logic              hit
);

  logic prev_q;
  logic prev_d;

  always_comb begin
    prev_d = smp;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
    end else begin
      prev_q <= prev_d;
    end
  end

  always_comb begin
    hit = trig_hit(trig_mode_e'(mode[2:0]), smp, prev_q);
  end

endmodule

// File: rtl/gpio_in_irq_regs.sv
module gpio_in_irq_regs
  import gpio_in_irq_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int DLY_W  = 2,
  parameter int MODE_W = 3,
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ADDR_W-1:0]        addr,
  input  logic                     wr,
  input  logic [DATA_W-1:0]        wdata,
  input  logic [NUM_CH-1:0]        smp,
  input  logic [NUM_CH-1:0]        hit,
  output logic [NUM_CH*DLY_W-1:0]  dly_cfg,
  output logic [NUM_CH*MODE_W-1:0] mode_cfg,
  output logic [NUM_CH-1:0]        raw,
  output logic [NUM_CH-1:0]        ena,
  output logic [NUM_CH-1:0]        sts,
  output logic [NUM_CH-1:0]        clr_pulse,
  output logic [DATA_W-1:0]        rdata
);

  localparam int DLY_BITS  = NUM_CH * DLY_W;
  localparam int MODE_BITS = NUM_CH * MODE_W;

  logic [DLY_BITS-1:0]  dly_q,  dly_d;
  logic [MODE_BITS-1:0] mode_q, mode_d;
  logic [NUM_CH-1:0]    raw_q,  raw_d;
  logic [NUM_CH-1:0]    ena_q,  ena_d;

  logic wr_dly, wr_mode, wr_ena, wr_clr;
  logic unused_wdata;

  // Write strobes per location
  assign wr_dly  = wr & (addr == ADDR_W'(OFF_DLY));
  assign wr_mode = wr & (addr == ADDR_W'(OFF_TRIG));
  assign wr_ena  = wr & (addr == ADDR_W'(OFF_ENA));
  assign wr_clr  = wr & (addr == ADDR_W'(OFF_CLR));

  assign unused_wdata = ^wdata[DATA_W-1:MODE_BITS];

  // Next-state
  always_comb begin
    dly_d     = wr_dly  ? wdata[DLY_BITS-1:0]  : dly_q;
    mode_d    = wr_mode ? wdata[MODE_BITS-1:0] : mode_q;
    ena_d     = wr_ena  ? wdata[NUM_CH-1:0]    : ena_q;
    clr_pulse = {NUM_CH{wr_clr}} & wdata[NUM_CH-1:0];
    // A hit in the clearing cycle keeps the flag
    raw_d     = (raw_q & ~clr_pulse) | hit;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dly_q  <= '0;
      mode_q <= '0;
      ena_q  <= '0;
      raw_q  <= '0;
    end else begin
      dly_q  <= dly_d;
      mode_q <= mode_d;
      ena_q  <= ena_d;
      raw_q  <= raw_d;
    end
  end

  assign dly_cfg  = dly_q;
  assign mode_cfg = mode_q;
  assign raw      = raw_q;
  assign ena      = ena_q;
  assign sts      = raw_q & ena_q;

  // Read decode
  always_comb begin
    rdata = '0;
    case (addr)
      ADDR_W'(OFF_DLY):   rdata[DLY_BITS-1:0]  = dly_q;
      ADDR_W'(OFF_INSTS): rdata[NUM_CH-1:0]    = smp;
      ADDR_W'(OFF_TRIG):  rdata[MODE_BITS-1:0] = mode_q;
      ADDR_W'(OFF_RAW):   rdata[NUM_CH-1:0]    = raw_q;
      ADDR_W'(OFF_ENA):   rdata[NUM_CH-1:0]    = ena_q;
      ADDR_W'(OFF_STS):   rdata[NUM_CH-1:0]    = raw_q & ena_q;
      default:            rdata = '0;
    endcase
  end

endmodule

// File: rtl/gpio_in_irq.sv
module gpio_in_irq #(
  parameter int NUM_CH = 8,
  parameter int DLY_W  = 2,
  parameter int MODE_W = 3,
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] pad_in,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);

  localparam int DLY_BITS  = NUM_CH * DLY_W;
  localparam int MODE_BITS = NUM_CH * MODE_W;

  // Reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end

  assign rst_q = rst_pipe[1];

  logic [NUM_CH-1:0]    sync_v;
  logic [NUM_CH-1:0]    dly_v;
  logic [NUM_CH-1:0]    hit_v;
  logic [NUM_CH-1:0]    raw_v;
  logic [NUM_CH-1:0]    en_v;
  logic [NUM_CH-1:0]    sts_v;
  logic [NUM_CH-1:0]    clr_v;
  logic [DLY_BITS-1:0]  dly_cfg_v;
  logic [MODE_BITS-1:0] mode_v;

  gpio_in_irq_sync #(.W(NUM_CH)) u_sync (
    .clk   (clk),
    .rst_n (rst_q),
    .d     (pad_in),
    .q     (sync_v)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    gpio_in_irq_dly_lane #(.SEL_W(DLY_W)) u_lane (
      .clk   (clk),
      .rst_n (rst_q),
      .din   (sync_v[ch]),
      .sel   (dly_cfg_v[ch*DLY_W +: DLY_W]),
      .dout  (dly_v[ch])
    );

    gpio_in_irq_edge_det #(.MODE_W(MODE_W)) u_det (
      .clk   (clk),
      .rst_n (rst_q),
      .smp   (dly_v[ch]),
      .mode  (mode_v[ch*MODE_W +: MODE_W]),
      .hit   (hit_v[ch])
    );
  end

  gpio_in_irq_regs #(
    .NUM_CH (NUM_CH),
    .DLY_W  (DLY_W),
    .MODE_W (MODE_W),
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_q),
    .addr      (bus_addr),
    .wr        (bus_wr),
    .wdata     (bus_wdata),
    .smp       (dly_v),
    .hit       (hit_v),
    .dly_cfg   (dly_cfg_v),
    .mode_cfg  (mode_v),
    .raw       (raw_v),
    .ena       (en_v),
    .sts       (sts_v),
    .clr_pulse (clr_v),
    .rdata     (bus_rdata)
  );

  assign irq = |sts_v;

endmodule

// File: rtl/gpio_in_irq_chk.sv
module gpio_in_irq_chk #(
  parameter int NUM_CH = 8,
  parameter int DLY_W  = 2,
  parameter int MODE_W = 3
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     irq,
  input logic [NUM_CH-1:0]        raw_q,
  input logic [NUM_CH-1:0]        en_q,
  input logic [NUM_CH-1:0]        hit,
  input logic [NUM_CH-1:0]        clr_pulse,
  input logic [NUM_CH*MODE_W-1:0] mode_cfg,
  input logic [NUM_CH*DLY_W-1:0]  dly_cfg,
  input logic [NUM_CH-1:0]        sync_v,
  input logic [NUM_CH-1:0]        dly_v
);

  assert_irq_needs_enable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> !irq);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    assert_raw_set_by_hit_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(raw_q[i]) |-> $past(hit[i]));

    assert_clear_drops_raw_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $past(clr_pulse[i] && !hit[i]) |-> !raw_q[i]);

    assert_raw_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $past(raw_q[i] && !clr_pulse[i]) |-> raw_q[i]);

    assert_off_mode_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_cfg[i*MODE_W+2 -: 2] == 2'b00) |-> !hit[i]);

    assert_zero_delay_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (dly_cfg[i*DLY_W +: DLY_W] == '0) |-> (dly_v[i] == sync_v[i]));
  end

endmodule

bind gpio_in_irq gpio_in_irq_chk #(
  .NUM_CH (NUM_CH),
  .DLY_W  (DLY_W),
  .MODE_W (MODE_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_q),
  .irq       (irq),
  .raw_q     (raw_v),
  .en_q      (en_v),
  .hit       (hit_v),
  .clr_pulse (clr_v),
  .mode_cfg  (mode_v),
  .dly_cfg   (dly_cfg_v),
  .sync_v    (sync_v),
  .dly_v     (dly_v)
);

// File: tb/gpio_in_irq_test.sv
`timescale 1ns/1ps
module gpio_in_irq_test;

  localparam int CLK_HALF = 10;
  localparam int NV = 46;

  // op: 0 write, 1 read-compare, 2 set pads, 3 wait cycles, 4 irq-compare
  // fields: op[44:42] req[41:38] addr[37:32] val[31:0]
  localparam logic [44:0] VEC [NV] = '{
    {3'd1, 4'd1,  6'h14, 32'h0},      // R1 delay cleared
    {3'd1, 4'd1,  6'h1C, 32'h0},      // R1 trigger cleared
    {3'd1, 4'd1,  6'h20, 32'h0},      // R1 raw cleared
    {3'd1, 4'd1,  6'h24, 32'h0},      // R1 enable cleared
    {3'd1, 4'd1,  6'h28, 32'h0},      // R1 status cleared
    {3'd4, 4'd1,  6'h00, 32'h0},      // R1 irq low
    {3'd1, 4'd10, 6'h00, 32'h0},      // R10 unmapped read
    {3'd0, 4'd10, 6'h14, 32'hE4},     // delays ch0..3 = 0,1,2,3
    {3'd1, 4'd10, 6'h14, 32'hE4},     // R10 readback
    {3'd2, 4'd2,  6'h00, 32'h0F},
    {3'd1, 4'd2,  6'h18, 32'h00},     // R2 one edge: still in synchronizer
    {3'd1, 4'd2,  6'h18, 32'h01},     // R2 k=0 after 2 edges
    {3'd1, 4'd2,  6'h18, 32'h03},     // R2 k=1
    {3'd1, 4'd2,  6'h18, 32'h07},     // R2 k=2
    {3'd1, 4'd2,  6'h18, 32'h0F},     // R2 k=3
    {3'd0, 4'd2,  6'h14, 32'h0},
    {3'd2, 4'd2,  6'h00, 32'h00},
    {3'd3, 4'd2,  6'h00, 32'd2},
    {3'd1, 4'd2,  6'h18, 32'h00},     // R2 back to zero
    {3'd0, 4'd10, 6'h1C, 32'h7E953},  // hi,lo,rise,fall,both,both,off,off
    {3'd1, 4'd10, 6'h1C, 32'h7E953},  // R10 trigger readback
    {3'd1, 4'd4,  6'h20, 32'h02},     // R4 low level on ch1
    {3'd0, 4'd8,  6'h2C, 32'h02},
    {3'd1, 4'd8,  6'h20, 32'h02},     // R8 set wins over clear
    {3'd2, 4'd5,  6'h00, 32'hFF},
    {3'd3, 4'd5,  6'h00, 32'd2},
    {3'd1, 4'd5,  6'h20, 32'h37},     // R5 rise/both, R3 ch6/ch7 silent, R4 high
    {3'd0, 4'd8,  6'h2C, 32'hFF},
    {3'd1, 4'd4,  6'h20, 32'h01},     // R4 high level re-sets, R8 others cleared
    {3'd0, 4'd6,  6'h20, 32'h00},
    {3'd1, 4'd6,  6'h20, 32'h01},     // R6 raw write ignored
    {3'd2, 4'd5,  6'h00, 32'h00},
    {3'd3, 4'd5,  6'h00, 32'd2},
    {3'd1, 4'd5,  6'h20, 32'h3B},     // R5 fall/both, low, sticky ch0
    {3'd0, 4'd7,  6'h24, 32'h0A},
    {3'd1, 4'd7,  6'h24, 32'h0A},     // R7 enable readback
    {3'd1, 4'd7,  6'h28, 32'h0A},     // R7 status = raw & enable
    {3'd4, 4'd9,  6'h00, 32'h1},      // R9 irq high
    {3'd0, 4'd8,  6'h2C, 32'h08},
    {3'd1, 4'd8,  6'h20, 32'h33},     // R8 only selected bit cleared
    {3'd1, 4'd7,  6'h28, 32'h02},     // R7
    {3'd4, 4'd9,  6'h00, 32'h1},      // R9
    {3'd0, 4'd7,  6'h24, 32'h08},
    {3'd1, 4'd7,  6'h28, 32'h00},     // R7 masked out
    {3'd4, 4'd9,  6'h00, 32'h0},      // R9 irq low with no status
    {3'd1, 4'd10, 6'h2C, 32'h00}      // R10 clear offset reads zero
  };

  logic        clk;
  logic        rst_n;
  logic [7:0]  pad_in;
  logic [5:0]  bus_addr;
  logic        bus_wr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        irq;

  int n_checks;
  int n_fail;

  gpio_in_irq uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .pad_in    (pad_in),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq       (irq)
  );

  initial clk = 1'b0;
  always #CLK_HALF clk = ~clk;

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  task automatic check_val(input int req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d: got 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_write(input logic [5:0] a, input logic [31:0] d);
    bus_addr  = a;
    bus_wdata = d;
    bus_wr    = 1'b1;
    @(negedge clk);
    bus_wr    = 1'b0;
  endtask

  task automatic do_read(input int req, input logic [5:0] a, input logic [31:0] exp);
    bus_addr = a;
    #2;
    check_val(req, bus_rdata, exp);
    @(negedge clk);
  endtask

  // Watchdog
  initial begin
    #(200000 * 2 * CLK_HALF);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    finish_run();
  end

  initial begin
    n_checks  = 0;
    n_fail    = 0;
    rst_n     = 1'b0;
    pad_in    = '0;
    bus_addr  = '0;
    bus_wr    = 1'b0;
    bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      case (VEC[i][44:42])
        3'd0: do_write(VEC[i][37:32], VEC[i][31:0]);
        3'd1: do_read(int'(VEC[i][41:38]), VEC[i][37:32], VEC[i][31:0]);
        3'd2: begin
          pad_in = VEC[i][7:0];
          @(negedge clk);
        end
        3'd3: repeat (int'(VEC[i][31:0])) @(negedge clk);
        default: begin
          #2;
          check_val(int'(VEC[i][41:38]), {31'd0, irq}, VEC[i][31:0]);
          @(negedge clk);
        end
      endcase
    end

    // Directed: reset in the middle of activity (R1)
    do_write(6'h24, 32'hFF);
    check_val(9, {31'd0, irq}, 32'h1); // R9 status pending before reset
    rst_n = 1'b0;
    #2;
    check_val(1, {31'd0, irq}, 32'h0);  // R1 async clear of interrupt
    bus_addr = 6'h20; #1; check_val(1, bus_rdata, 32'h0); // R1 raw
    bus_addr = 6'h24; #1; check_val(1, bus_rdata, 32'h0); // R1 enable
    bus_addr = 6'h1C; #1; check_val(1, bus_rdata, 32'h0); // R1 trigger
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    do_read(1, 6'h28, 32'h0);            // R1 status stays clear

    // Directed: delay 3 on ch7 with either-edge trigger (R2, R5)
    do_write(6'h14, 32'hC000);
    do_write(6'h1C, 32'h00E00000);
    pad_in = 8'h80;
    repeat (5) @(negedge clk);          // edges 1..5: delayed value arrives at edge 5
    do_read(5, 6'h20, 32'h00);          // R5 raw not yet set (reads after edge 5)
    do_read(5, 6'h20, 32'h80);          // R5 set one edge later
    do_read(2, 6'h18, 32'h80);          // R2 delayed level visible

    finish_run();
  end

endmodule